// File: doc/BRIEF.md
# Bank Activation Timing Checker

This block observes a DDR2-style command bus and keeps a model of four banks: whether each holds an open row, which row that is, and how many cycles have passed since its last activate and its last precharge. Every command is checked against the row-open rules and the minimum spacings between commands. Each kind of violation produces its own one-cycle flag, together with the bank address of the offending command. The timing limits, the additive latency and the CAS latency are configuration inputs. These inputs are expected to change only while the bus is idle.

Column commands may be posted early. With a nonzero additive latency, a read or write is accepted this many cycles sooner than the row-to-column delay would otherwise allow. For every read command the block also raises a strobe in the cycle the read data is due, which is the additive latency plus the CAS latency after the command. The strobe carries the bank that was read. A violating command still updates the bank model, so tracking stays aligned with what the memory itself would do.

Top module: `ddr_bank_timing_checker`

## Requirements
- R1: The bus is sampled on the rising clock edge, and a command is decoded only while csN is low. Activate is rasN low with casN and weN high. Precharge is rasN and weN low with casN high; address bit 10 high selects all banks. Read or write is casN low with rasN high, and weN high means read.
- R2: After reset all banks are idle, every error output and rdDue are low, and every spacing rule counts as already met.
- R3: A read or write to an open bank raises errTrcd when the cycles since that bank's activate plus cfgAddLat are fewer than cfgTrcd.
- R4: A read or write to a bank with no open row raises errNoRow.
- R5: An activate to a bank whose open row differs from the addressed row raises errRowOpen.
- R6: A precharge that closes an open bank fewer than cfgTras cycles after that bank's activate raises errTras. A precharge aimed at an idle bank raises no error and leaves that bank's precharge time unchanged.
- R7: An activate fewer than cfgTrp cycles after that bank's last precharge raises errTrp.
- R8: An activate fewer than cfgTras plus cfgTrp cycles after the same bank's previous activate raises errTrc.
- R9: An activate to a bank other than the most recently activated one, issued fewer than cfgTrrd cycles after that activate, raises errTrrd.
- R10: Every read, including a flagged one, makes rdDue high for exactly one cycle, ending at the edge cfgAddLat plus cfgCasLat cycles after the read's edge; a sum of zero counts as one. rdDueBank gives the read's bank. Writes never raise rdDue.
- R11: A violating command is still applied to the bank model. An activate opens the row, a precharge closes the row, and a precharge to all banks closes every open bank.
- R12: The error outputs are high only in the cycle after the edge that sampled the offending command. While any of them is high, errBank equals that command's bank address.
- R13: The cycle counters saturate, so a command issued after an arbitrarily long gap meets every spacing rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the bus is sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankAddr | input | 2 | Bank address of the command |
| addr | input | 14 | Row address; bit 10 selects all banks on precharge |
| cfgTrcd | input | 5 | Activate-to-column minimum, in cycles |
| cfgTras | input | 5 | Activate-to-precharge minimum, in cycles |
| cfgTrp | input | 5 | Precharge-to-activate minimum, in cycles |
| cfgTrrd | input | 5 | Activate-to-activate minimum across banks, in cycles |
| cfgAddLat | input | 5 | Additive latency, in cycles |
| cfgCasLat | input | 5 | CAS latency, in cycles |
| errRowOpen | output | 1 | Activate to a bank that has a different row open |
| errNoRow | output | 1 | Read or write to an idle bank |
| errTrcd | output | 1 | Column command too soon after activate |
| errTras | output | 1 | Precharge too soon after activate |
| errTrp | output | 1 | Activate too soon after precharge |
| errTrc | output | 1 | Activate too soon after the same bank's previous activate |
| errTrrd | output | 1 | Activate too soon after an activate to another bank |
| errBank | output | 2 | Bank address of the flagged command |
| rdDue | output | 1 | Read data is due at the coming edge |
| rdDueBank | output | 2 | Bank of the read whose data is due |

## Verification
The properties assume that csN is held high throughout reset, so that the first cycle after reset refers back to a quiet bus. They also assume the configuration inputs are stable whenever a command is in flight. The stimulus enforces both: every command is driven on the falling edge and returned to a no-operation after one rising edge, and the latency settings are changed only during idle stretches. The bench also keeps each cfgAddLat plus cfgCasLat sum inside the read pipeline's depth.

// File: rtl/ddr_act_pkg.sv
package ddr_act_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int ROW_W     = 14;
  localparam int AP_BIT    = 10;
  localparam int CFG_W     = 5;
  localparam int CNT_W     = CFG_W + 1;
  localparam int CNT_MAX   = (1 << CNT_W) - 1;
  localparam int RL_MAX    = 2 * ((1 << CFG_W) - 1);
  localparam int RL_W      = $clog2(RL_MAX + 1);

  typedef logic [CNT_W-1:0] cnt_t;

  // Strobes from control to datapath, valid for the current edge
  typedef struct packed {
    logic                 actValid;
    logic [BANK_W-1:0]    cmdBank;
    logic [ROW_W-1:0]     actRow;
    logic [NUM_BANKS-1:0] closeMask;
    logic                 rdValid;
    logic [RL_W-1:0]      rdLat;
  } strobe_t;

  typedef struct packed {
    logic rowOpen;
    logic noRow;
    logic trcd;
    logic tras;
    logic trp;
    logic trc;
    logic trrd;
  } err_t;
endpackage

// File: rtl/dbt_bank_dp.sv
module dbt_bank_dp
  import ddr_act_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  strobe_t                             stb,
  output logic [NUM_BANKS-1:0]                bankOpen,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]     openRow,
  output logic [NUM_BANKS-1:0][CNT_W-1:0]     sinceAct,
  output logic [NUM_BANKS-1:0][CNT_W-1:0]     sincePre,
  output cnt_t                                sinceAnyAct,
  output logic [BANK_W-1:0]                   lastActBank,
  output logic                                rdDue,
  output logic [BANK_W-1:0]                   rdDueBank
);

  function automatic cnt_t satInc(input cnt_t v);
    return (v == cnt_t'(CNT_MAX)) ? v : v + cnt_t'(1);
  endfunction

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             hitAct;
    logic             hitPre;
    logic             openQ;
    logic [ROW_W-1:0] rowQ;
    cnt_t             actCntQ;
    cnt_t             preCntQ;

    assign hitAct = stb.actValid && (stb.cmdBank == BANK_W'(b));
    assign hitPre = stb.closeMask[b];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ   <= 1'b0;
        rowQ    <= '0;
        actCntQ <= cnt_t'(CNT_MAX);
        preCntQ <= cnt_t'(CNT_MAX);
      end else begin
        if (hitAct) begin
          openQ <= 1'b1;
          rowQ  <= stb.actRow;
        end else if (hitPre) begin
          openQ <= 1'b0;
        end
        actCntQ <= hitAct ? cnt_t'(1) : satInc(actCntQ);
        preCntQ <= hitPre ? cnt_t'(1) : satInc(preCntQ);
      end
    end

    assign bankOpen[b] = openQ;
    assign openRow[b]  = rowQ;
    assign sinceAct[b] = actCntQ;
    assign sincePre[b] = preCntQ;
  end

  // Spacing since the most recent activate to any bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAnyAct <= cnt_t'(CNT_MAX);
      lastActBank <= '0;
    end else if (stb.actValid) begin
      sinceAnyAct <= cnt_t'(1);
      lastActBank <= stb.cmdBank;
    end else begin
      sinceAnyAct <= satInc(sinceAnyAct);
    end
  end

  // Read-data-due pipeline: slot 0 is the slot due at the coming edge
  logic [RL_MAX-1:0]             pipeV, nextV;
  logic [RL_MAX-1:0][BANK_W-1:0] pipeB, nextB;
  logic [RL_W-1:0]               slot;

  assign slot = stb.rdLat - RL_W'(1);

  always_comb begin
    nextV = {1'b0, pipeV[RL_MAX-1:1]};
    nextB = {BANK_W'(0), pipeB[RL_MAX-1:1]};
    if (stb.rdValid) begin
      nextV[slot] = 1'b1;
      nextB[slot] = stb.cmdBank;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeV <= '0;
      pipeB <= '0;
    end else begin
      pipeV <= nextV;
      pipeB <= nextB;
    end
  end

  assign rdDue     = pipeV[0];
  assign rdDueBank = pipeB[0];
endmodule

// File: rtl/dbt_ctrl.sv
module dbt_ctrl
  import ddr_act_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            csN,
  input  logic                            rasN,
  input  logic                            casN,
  input  logic                            weN,
  input  logic [BANK_W-1:0]               bankAddr,
  input  logic [ROW_W-1:0]                addr,
  input  logic [CFG_W-1:0]                cfgTrcd,
  input  logic [CFG_W-1:0]                cfgTras,
  input  logic [CFG_W-1:0]                cfgTrp,
  input  logic [CFG_W-1:0]                cfgTrrd,
  input  logic [CFG_W-1:0]                cfgAddLat,
  input  logic [CFG_W-1:0]                cfgCasLat,
  input  logic [NUM_BANKS-1:0]            bankOpen,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0] openRow,
  input  logic [NUM_BANKS-1:0][CNT_W-1:0] sinceAct,
  input  logic [NUM_BANKS-1:0][CNT_W-1:0] sincePre,
  input  cnt_t                            sinceAnyAct,
  input  logic [BANK_W-1:0]               lastActBank,
  output strobe_t                         stb,
  output err_t                            errQ,
  output logic [BANK_W-1:0]               errBankQ
);

  logic isAct, isPre, isCol, isRead;
  assign isAct  = !csN && !rasN &&  casN &&  weN;
  assign isPre  = !csN && !rasN &&  casN && !weN;
  assign isCol  = !csN &&  rasN && !casN;
  assign isRead = isCol && weN;

  logic             curOpen;
  logic [ROW_W-1:0] curRow;
  cnt_t             curSinceAct;
  cnt_t             curSincePre;
  assign curOpen     = bankOpen[bankAddr];
  assign curRow      = openRow[bankAddr];
  assign curSinceAct = sinceAct[bankAddr];
  assign curSincePre = sincePre[bankAddr];

  logic [CNT_W:0] effColDist;
  cnt_t           cycleMin;
  logic [CNT_W:0] latSum;
  assign effColDist = (CNT_W+1)'(curSinceAct) + (CNT_W+1)'(cfgAddLat);
  assign cycleMin   = cnt_t'(cfgTras) + cnt_t'(cfgTrp);
  assign latSum     = (CNT_W+1)'(cfgAddLat) + (CNT_W+1)'(cfgCasLat);

  logic [NUM_BANKS-1:0] targetMask;
  logic [NUM_BANKS-1:0] closeMask;
  logic [NUM_BANKS-1:0] rasShort;
  always_comb begin
    for (int i = 0; i < NUM_BANKS; i++) begin
      targetMask[i] = addr[AP_BIT] || (bankAddr == BANK_W'(i));
      rasShort[i]   = sinceAct[i] < cnt_t'(cfgTras);
    end
    closeMask = isPre ? (targetMask & bankOpen) : '0;
  end

  err_t errNext;
  always_comb begin
    errNext         = '0;
    errNext.noRow   = isCol && !curOpen;
    errNext.trcd    = isCol && curOpen && (effColDist < (CNT_W+1)'(cfgTrcd));
    errNext.tras    = |(closeMask & rasShort);
    errNext.rowOpen = isAct && curOpen && (curRow != addr);
    errNext.trp     = isAct && (curSincePre < cnt_t'(cfgTrp));
    errNext.trc     = isAct && (curSinceAct < cycleMin);
    errNext.trrd    = isAct && (bankAddr != lastActBank) &&
                      (sinceAnyAct < cnt_t'(cfgTrrd));
  end

  always_comb begin
    stb           = '0;
    stb.actValid  = isAct;
    stb.cmdBank   = bankAddr;
    stb.actRow    = addr;
    stb.closeMask = closeMask;
    stb.rdValid   = isRead;
    if (latSum == '0)
      stb.rdLat = RL_W'(1);
    else if (latSum > (CNT_W+1)'(RL_MAX))
      stb.rdLat = RL_W'(RL_MAX);
    else
      stb.rdLat = RL_W'(latSum);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errQ     <= '0;
      errBankQ <= '0;
    end else begin
      errQ     <= errNext;
      errBankQ <= bankAddr;
    end
  end
endmodule

// File: rtl/ddr_bank_timing_checker.sv
module ddr_bank_timing_checker
  import ddr_act_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BANK_W-1:0] bankAddr,
  input  logic [ROW_W-1:0]  addr,
  input  logic [CFG_W-1:0]  cfgTrcd,
  input  logic [CFG_W-1:0]  cfgTras,
  input  logic [CFG_W-1:0]  cfgTrp,
  input  logic [CFG_W-1:0]  cfgTrrd,
  input  logic [CFG_W-1:0]  cfgAddLat,
  input  logic [CFG_W-1:0]  cfgCasLat,
  output logic              errRowOpen,
  output logic              errNoRow,
  output logic              errTrcd,
  output logic              errTras,
  output logic              errTrp,
  output logic              errTrc,
  output logic              errTrrd,
  output logic [BANK_W-1:0] errBank,
  output logic              rdDue,
  output logic [BANK_W-1:0] rdDueBank
);

  strobe_t                         stb;
  err_t                            errQ;
  logic [NUM_BANKS-1:0]            bankOpen;
  logic [NUM_BANKS-1:0][ROW_W-1:0] openRow;
  logic [NUM_BANKS-1:0][CNT_W-1:0] sinceAct;
  logic [NUM_BANKS-1:0][CNT_W-1:0] sincePre;
  cnt_t                            sinceAnyAct;
  logic [BANK_W-1:0]               lastActBank;

  dbt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .bankAddr   (bankAddr),
    .addr       (addr),
    .cfgTrcd    (cfgTrcd),
    .cfgTras    (cfgTras),
    .cfgTrp     (cfgTrp),
    .cfgTrrd    (cfgTrrd),
    .cfgAddLat  (cfgAddLat),
    .cfgCasLat  (cfgCasLat),
    .bankOpen   (bankOpen),
    .openRow    (openRow),
    .sinceAct   (sinceAct),
    .sincePre   (sincePre),
    .sinceAnyAct(sinceAnyAct),
    .lastActBank(lastActBank),
    .stb        (stb),
    .errQ       (errQ),
    .errBankQ   (errBank)
  );

  dbt_bank_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .bankOpen   (bankOpen),
    .openRow    (openRow),
    .sinceAct   (sinceAct),
    .sincePre   (sincePre),
    .sinceAnyAct(sinceAnyAct),
    .lastActBank(lastActBank),
    .rdDue      (rdDue),
    .rdDueBank  (rdDueBank)
  );

  assign errRowOpen = errQ.rowOpen;
  assign errNoRow   = errQ.noRow;
  assign errTrcd    = errQ.trcd;
  assign errTras    = errQ.tras;
  assign errTrp     = errQ.trp;
  assign errTrc     = errQ.trc;
  assign errTrrd    = errQ.trrd;
endmodule

// File: rtl/ddr_bank_timing_sva.sv
module ddr_bank_timing_sva
  import ddr_act_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [BANK_W-1:0] bankAddr,
  input logic              errRowOpen,
  input logic              errNoRow,
  input logic              errTrcd,
  input logic              errTras,
  input logic              errTrp,
  input logic              errTrc,
  input logic              errTrrd,
  input logic [BANK_W-1:0] errBank
);
  logic anyErr;
  assign anyErr = errRowOpen | errNoRow | errTrcd | errTras | errTrp | errTrc | errTrrd;

  AST_QUIET_BUS_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN) |-> !anyErr); // R12
  AST_ERR_BANK_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    anyErr |-> (errBank == $past(bankAddr))); // R12
  AST_TRCD_ON_COLUMN: assert property (@(posedge clk) disable iff (!rstN)
    errTrcd |-> $past(!csN && rasN && !casN)); // R3
  AST_NOROW_ON_COLUMN: assert property (@(posedge clk) disable iff (!rstN)
    errNoRow |-> $past(!csN && rasN && !casN)); // R4
  AST_ROWOPEN_ON_ACT: assert property (@(posedge clk) disable iff (!rstN)
    errRowOpen |-> $past(!csN && !rasN && casN && weN)); // R5
  AST_TRAS_ON_PRE: assert property (@(posedge clk) disable iff (!rstN)
    errTras |-> $past(!csN && !rasN && casN && !weN)); // R6
  AST_TRP_ON_ACT: assert property (@(posedge clk) disable iff (!rstN)
    errTrp |-> $past(!csN && !rasN && casN && weN)); // R7
  AST_TRC_ON_ACT: assert property (@(posedge clk) disable iff (!rstN)
    errTrc |-> $past(!csN && !rasN && casN && weN)); // R8
  AST_TRRD_ON_ACT: assert property (@(posedge clk) disable iff (!rstN)
    errTrrd |-> $past(!csN && !rasN && casN && weN)); // R9
  AST_ONE_COMMAND_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errNoRow | errTrcd, errTras, errRowOpen | errTrp | errTrc | errTrrd})); // R1
endmodule

bind ddr_bank_timing_checker ddr_bank_timing_sva u_sva (.*);

// File: tb/tb_ddr_bank_timing_checker.sv
module tb_ddr_bank_timing_checker;
  localparam int CLK_PERIOD = 10;
  localparam int K_ACT = 0, K_PRE = 1, K_PREALL = 2, K_RD = 3, K_WR = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0]  bankAddr = '0;
  logic [13:0] addr = '0;
  logic [4:0]  cfgTrcd = 5'd3, cfgTras = 5'd6, cfgTrp = 5'd3, cfgTrrd = 5'd2;
  logic [4:0]  cfgAddLat = 5'd2, cfgCasLat = 5'd3;
  logic errRowOpen, errNoRow, errTrcd, errTras, errTrp, errTrc, errTrrd;
  logic [1:0] errBank;
  logic rdDue;
  logic [1:0] rdDueBank;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;
  int expDueCyc[$];
  int expDueBank[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_bank_timing_checker dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankAddr(bankAddr), .addr(addr), .cfgTrcd(cfgTrcd), .cfgTras(cfgTras),
    .cfgTrp(cfgTrp), .cfgTrrd(cfgTrrd), .cfgAddLat(cfgAddLat), .cfgCasLat(cfgCasLat),
    .errRowOpen(errRowOpen), .errNoRow(errNoRow), .errTrcd(errTrcd), .errTras(errTras),
    .errTrp(errTrp), .errTrc(errTrc), .errTrrd(errTrrd), .errBank(errBank),
    .rdDue(rdDue), .rdDueBank(rdDueBank)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // Flag order: rowOpen noRow trcd tras trp trc trrd
  function automatic logic [6:0] flags();
    return {errRowOpen, errNoRow, errTrcd, errTras, errTrp, errTrc, errTrrd};
  endfunction

  // Monitor: compare each rdDue pulse to the scoreboard head
  always @(negedge clk) begin
    if (rstN && rdDue) begin
      if (expDueCyc.size() == 0) begin
        check("R10 unexpected rdDue", 1, 0);
      end else begin
        check("R10 rdDue cycle", cyc + 1, expDueCyc.pop_front());
        check("R10 rdDueBank", rdDueBank, expDueBank.pop_front());
      end
    end
  end

  task automatic nop(input int n);
    @(negedge clk);
    csN = 1'b1; rasN = 1'b1; casN = 1'b1; weN = 1'b1;
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Driver: issue one command, push expected read data, check flags
  task automatic cmd(input int kind, input logic [1:0] b, input logic [13:0] row,
                     input logic [6:0] expFlags, input string req);
    int rl;
    @(negedge clk);
    csN = 1'b0; bankAddr = b; addr = row;
    case (kind)
      K_ACT:    begin rasN = 1'b0; casN = 1'b1; weN = 1'b1; end
      K_PRE:    begin rasN = 1'b0; casN = 1'b1; weN = 1'b0; addr[10] = 1'b0; end
      K_PREALL: begin rasN = 1'b0; casN = 1'b1; weN = 1'b0; addr[10] = 1'b1; end
      K_RD:     begin rasN = 1'b1; casN = 1'b0; weN = 1'b1; end
      default:  begin rasN = 1'b1; casN = 1'b0; weN = 1'b0; end
    endcase
    @(posedge clk);
    #1;
    if (kind == K_RD) begin
      rl = int'(cfgAddLat) + int'(cfgCasLat);
      if (rl == 0) rl = 1;
      expDueCyc.push_back(cyc + rl);
      expDueBank.push_back(int'(b));
    end
    check(req, flags(), expFlags);
    if (expFlags != 7'd0) check({req, " errBank"}, errBank, b);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset flags", flags(), 0);
    check("R2 reset rdDue", rdDue, 0);
    @(negedge clk);
    rstN = 1'b1;
    nop(2);
    check("R2 idle after reset", flags(), 0);

    cmd(K_RD,  2'd0, 14'd0,  7'b0100000, "R4 read idle bank");
    cmd(K_ACT, 2'd0, 14'd5,  7'b0000000, "R1 R13 first activate");
    nop(1);
    cmd(K_RD,  2'd0, 14'd0,  7'b0000000, "R3 posted read meets trcd via AL");
    cmd(K_ACT, 2'd1, 14'd7,  7'b0000000, "R9 activate at trrd");
    cmd(K_ACT, 2'd2, 14'd9,  7'b0000001, "R9 activate before trrd");
    cmd(K_RD,  2'd2, 14'd0,  7'b0000000, "R3 read one cycle after act AL2");
    cmd(K_WR,  2'd1, 14'd0,  7'b0000000, "R10 write no rdDue");
    cmd(K_PRE, 2'd0, 14'd0,  7'b0000000, "R6 precharge after tras");
    cmd(K_ACT, 2'd0, 14'd11, 7'b0000110, "R7 R8 early reactivate");
    cmd(K_ACT, 2'd0, 14'd12, 7'b1000110, "R5 R11 different row while open");
    cmd(K_PRE, 2'd0, 14'd0,  7'b0001000, "R6 precharge before tras");
    cmd(K_PRE, 2'd3, 14'd0,  7'b0000000, "R6 precharge idle bank");
    cmd(K_RD,  2'd0, 14'd0,  7'b0100000, "R11 flagged precharge closed bank");
    cmd(K_PREALL, 2'd2, 14'd0, 7'b0000000, "R1 precharge all");
    cmd(K_RD,  2'd1, 14'd0,  7'b0100000, "R11 precharge all closed bank");
    nop(8);
    cfgAddLat = 5'd0;
    nop(1);
    cmd(K_ACT, 2'd3, 14'd1,  7'b0000000, "R6 idle precharge left no trp");
    nop(1);
    cmd(K_RD,  2'd3, 14'd0,  7'b0010000, "R3 read before trcd AL0");
    cmd(K_RD,  2'd3, 14'd0,  7'b0000000, "R3 read at trcd AL0");
    nop(6);
    cfgCasLat = 5'd0;
    nop(1);
    cmd(K_RD,  2'd3, 14'd0,  7'b0000000, "R10 zero latency read");
    nop(100);
    cmd(K_ACT, 2'd1, 14'd2,  7'b0000000, "R13 activate after long gap");
    nop(80);
    check("R10 all reads delivered", expDueCyc.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule